// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block takes thirty-two interrupt sources and ranks them through thirty-two priority slots. Level 0 has the highest priority and level 31 the lowest. Software gives each slot a source number, a line choice (normal IRQ or fast FIQ), an enable bit and a handler address. The controller picks the highest-priority enabled slot whose source is active and drives that slot's line. A processor claims the interrupt by reading the handler-address register. That read returns the winning slot's address and masks that slot and every slot below it. Writing the same register releases the most recent claim.

Claims nest on a stack of thresholds, so a more urgent slot can preempt a running handler and be claimed in turn. A small state machine tracks the stack. It starts in `ST_OPEN`, where nothing is masked. The transition *claim* moves it from `ST_OPEN` to `ST_NESTED`. In `ST_NESTED`, *nest-claim* pushes a deeper threshold and *inner-release* pops one level, and both keep the state. *Last-release* empties the stack and returns to `ST_OPEN`.

The top four source numbers come from four external pins rather than from on-chip sources. Each pin has a trigger conditioner that works in one of four modes: rising edge, falling edge, high level or low level. An edge sets a sticky pending flag.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low. All levels are disabled, all handler addresses and configuration words read 0, nothing is masked, and status (0x41) reads 0.
- R2: The handler address of level L is read and written at offset 0x00+L. The configuration of level L is at offset 0x20+L, with bits [4:0] the source number, bit 5 FIQ select (1 = FIQ) and bit 6 enable. Levels that are disabled never win.
- R3: The winner is the lowest-numbered enabled, unmasked level whose assigned source is active. Several levels may name the same source.
- R4: The winner drives `fiq_o` when its FIQ bit is set and `irq_o` otherwise. Never both are high. Both follow the inputs within the same cycle.
- R5: Status at offset 0x41 reads bit 5 = a winner exists and bits [4:0] = the winning level (0 when there is none).
- R6: A read of offset 0x40 while a winner exists returns that level's handler address. From the next cycle, that level and all higher-numbered levels are masked.
- R7: A read of 0x40 with no winner returns 0 and leaves the mask unchanged.
- R8: Any write to 0x40 restores the threshold in force before the most recent claim, so claims nest and a more urgent level can preempt. A write with nothing claimed has no effect.
- R9: External pin k feeds source 28+k. Its control register is at 0x48+k, with bits [1:0] the mode: 00 rising edge, 01 falling edge, 10 high level, 11 low level. Level modes follow the pin within the same cycle.
- R10: In the edge modes, an edge seen at a clock edge sets a pending bit (control register bit 3). The bit stays set after the pin returns and drives the source. Writing the control register with bit 2 = 1 clears it, but an edge in the same cycle keeps it set.
- R11: When `reg_rd_i` and `reg_wr_i` are high together, the write takes effect and the claiming side effect of the read is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 28 | On-chip interrupt sources 0..27, active high |
| ext_pin_i | input | 4 | External interrupt pins feeding sources 28..31 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (claim side effect) |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current offset, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an edge on an external pin and a software clear of that pin's pending bit. The bench drives the pin's rising edge and the clearing write in the same cycle and expects the pending bit to survive. The second pair is a claiming read and a releasing write of the handler-address register. The bench raises both strobes together while a winner exists and expects only the release to act, with the winner still unmasked afterwards. A behavioural model with a queue for the threshold stack judges every cycle, and preemption is provoked by activating a more urgent source between a claim and its release.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        EXT_RISE = 2'b00,
        EXT_FALL = 2'b01,
        EXT_HIGH = 2'b10,
        EXT_LOW  = 2'b11
    } ext_mode_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_NESTED = 1'b1
    } mask_state_e;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_VEC  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CFG  = 8'h20;
    localparam logic [REG_AW-1:0] OFS_ISR  = 8'h40;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h41;
    localparam logic [REG_AW-1:0] OFS_EXT  = 8'h48;

    localparam int CFG_FIQ_BIT    = 5;
    localparam int CFG_EN_BIT     = 6;
    localparam int STAT_VALID_BIT = 5;
    localparam int EXT_CLR_BIT    = 2;
    localparam int EXT_PEND_BIT   = 3;

endpackage

// File: rtl/pvic_ext_trig.sv
module pvic_ext_trig
    import pvic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  logic      ctl_wr_i,
    input  ext_mode_e mode_d_i,
    input  logic      clr_i,
    output logic      act_o,
    output logic      pend_o,
    output ext_mode_e mode_o
);

    ext_mode_e mode_q;
    logic      prev_q;
    logic      pend_q;
    logic      edge_hit;

    // Edge detection uses the mode in force before any write this cycle
    always_comb begin
        unique case (mode_q)
            EXT_RISE: edge_hit = pin_i & ~prev_q;
            EXT_FALL: edge_hit = ~pin_i & prev_q;
            default:  edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= EXT_RISE;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
            if (ctl_wr_i) begin
                mode_q <= mode_d_i;
            end
            if (edge_hit) begin
                pend_q <= 1'b1;
            end else if (ctl_wr_i && clr_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (mode_q)
            EXT_HIGH: act_o = pin_i;
            EXT_LOW:  act_o = ~pin_i;
            default:  act_o = pend_q;
        endcase
        pend_o = pend_q;
        mode_o = mode_q;
    end

endmodule

// File: rtl/pvic_mask_stack.sv
module pvic_mask_stack
    import pvic_pkg::*;
#(
    parameter int NUM_LVL = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       claim_i,
    input  logic [$clog2(NUM_LVL)-1:0] claim_lvl_i,
    input  logic                       release_i,
    output logic [$clog2(NUM_LVL):0]   thr_o,
    output logic                       busy_o
);

    localparam int LVL_W = $clog2(NUM_LVL);
    localparam int THR_W = LVL_W + 1;

    mask_state_e      state_q, state_d;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] ptr_q;
    logic [THR_W-1:0] pop_idx;
    logic [THR_W-1:0] stk_q [NUM_LVL];
    logic             do_push;
    logic             do_pop;

    assign do_push = claim_i && (ptr_q < THR_W'(NUM_LVL));
    assign do_pop  = release_i && (state_q == ST_NESTED);
    assign pop_idx = ptr_q - THR_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: claim, nest-claim, inner-release, last-release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (do_push) begin
                    state_d = ST_NESTED;
                end
            end
            ST_NESTED: begin
                if (do_pop && (ptr_q == THR_W'(1))) begin
                    state_d = ST_OPEN;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_W'(NUM_LVL);
            ptr_q <= '0;
        end else if (do_push) begin
            thr_q <= {1'b0, claim_lvl_i};
            ptr_q <= ptr_q + THR_W'(1);
        end else if (do_pop) begin
            thr_q <= stk_q[pop_idx[LVL_W-1:0]];
            ptr_q <= pop_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            stk_q[ptr_q[LVL_W-1:0]] <= thr_q;
        end
    end

    // Outputs
    always_comb begin
        thr_o  = thr_q;
        busy_o = (state_q == ST_NESTED);
    end

endmodule

// File: rtl/pvic_prio_sel.sv
module pvic_prio_sel #(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 32
) (
    input  logic [NUM_SRC-1:0]                      src_act_i,
    input  logic [NUM_LVL-1:0]                      lvl_en_i,
    input  logic [NUM_LVL-1:0]                      lvl_fiq_i,
    input  logic [NUM_LVL-1:0][$clog2(NUM_SRC)-1:0] lvl_src_i,
    input  logic [$clog2(NUM_LVL):0]                thr_i,
    output logic                                    win_valid_o,
    output logic [$clog2(NUM_LVL)-1:0]              win_lvl_o,
    output logic                                    win_fiq_o
);

    localparam int LVL_W = $clog2(NUM_LVL);
    localparam int THR_W = LVL_W + 1;

    logic [NUM_LVL-1:0] hit;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign hit[g] = lvl_en_i[g] & src_act_i[lvl_src_i[g]] & (THR_W'(g) < thr_i);
    end

    always_comb begin
        win_valid_o = 1'b0;
        win_lvl_o   = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (hit[l]) begin
                win_valid_o = 1'b1;
                win_lvl_o   = LVL_W'(l);
            end
        end
        win_fiq_o = win_valid_o & lvl_fiq_i[win_lvl_o];
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 32,
    parameter int NUM_EXT = 4,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-NUM_EXT-1:0] src_i,
    input  logic [NUM_EXT-1:0]      ext_pin_i,
    input  logic                    reg_wr_i,
    input  logic                    reg_rd_i,
    input  logic [REG_AW-1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    output logic                    irq_o,
    output logic                    fiq_o
);

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int LVL_W = $clog2(NUM_LVL);
    localparam int THR_W = LVL_W + 1;
    localparam int EXT_W = $clog2(NUM_EXT);

    logic [DATA_W-1:0]             vec_q [NUM_LVL];
    logic [NUM_LVL-1:0]            en_q;
    logic [NUM_LVL-1:0]            fiq_q;
    logic [NUM_LVL-1:0][SRC_W-1:0] sid_q;

    logic [REG_AW-1:0] vec_off, cfg_off, ext_off;
    logic              is_vec, is_cfg, is_ext, is_isr, is_stat;
    logic [LVL_W-1:0]  vidx, cidx;
    logic [EXT_W-1:0]  eidx;

    logic [NUM_EXT-1:0] ext_act, ext_pend;
    ext_mode_e          ext_mode [NUM_EXT];
    logic [NUM_SRC-1:0] src_act;

    logic              win_valid, win_fiq;
    logic [LVL_W-1:0]  win_lvl;
    logic [THR_W-1:0]  thr;
    logic              claim, release_w, busy;

    // Register decode
    assign vec_off = reg_addr_i - OFS_VEC;
    assign cfg_off = reg_addr_i - OFS_CFG;
    assign ext_off = reg_addr_i - OFS_EXT;
    assign is_vec  = vec_off < REG_AW'(NUM_LVL);
    assign is_cfg  = cfg_off < REG_AW'(NUM_LVL);
    assign is_ext  = ext_off < REG_AW'(NUM_EXT);
    assign is_isr  = reg_addr_i == OFS_ISR;
    assign is_stat = reg_addr_i == OFS_STAT;
    assign vidx    = vec_off[LVL_W-1:0];
    assign cidx    = cfg_off[LVL_W-1:0];
    assign eidx    = ext_off[EXT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LVL; l++) begin
                vec_q[l] <= '0;
            end
            en_q  <= '0;
            fiq_q <= '0;
            sid_q <= '0;
        end else if (reg_wr_i) begin
            if (is_vec) begin
                vec_q[vidx] <= reg_wdata_i;
            end
            if (is_cfg) begin
                sid_q[cidx] <= reg_wdata_i[SRC_W-1:0];
                fiq_q[cidx] <= reg_wdata_i[CFG_FIQ_BIT];
                en_q[cidx]  <= reg_wdata_i[CFG_EN_BIT];
            end
        end
    end

    // External trigger conditioners
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        logic ctl_wr;
        assign ctl_wr = reg_wr_i && is_ext && (eidx == EXT_W'(k));
        pvic_ext_trig u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (ext_pin_i[k]),
            .ctl_wr_i (ctl_wr),
            .mode_d_i (ext_mode_e'(reg_wdata_i[1:0])),
            .clr_i    (reg_wdata_i[EXT_CLR_BIT]),
            .act_o    (ext_act[k]),
            .pend_o   (ext_pend[k]),
            .mode_o   (ext_mode[k])
        );
    end

    assign src_act = {ext_act, src_i};

    pvic_prio_sel #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL)
    ) u_sel (
        .src_act_i   (src_act),
        .lvl_en_i    (en_q),
        .lvl_fiq_i   (fiq_q),
        .lvl_src_i   (sid_q),
        .thr_i       (thr),
        .win_valid_o (win_valid),
        .win_lvl_o   (win_lvl),
        .win_fiq_o   (win_fiq)
    );

    // A write wins over a simultaneous read on the claim path
    assign claim     = reg_rd_i && !reg_wr_i && is_isr && win_valid;
    assign release_w = reg_wr_i && is_isr;

    pvic_mask_stack #(
        .NUM_LVL (NUM_LVL)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_i     (claim),
        .claim_lvl_i (win_lvl),
        .release_i   (release_w),
        .thr_o       (thr),
        .busy_o      (busy)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (is_vec) begin
            reg_rdata_o = vec_q[vidx];
        end else if (is_cfg) begin
            reg_rdata_o[SRC_W-1:0]   = sid_q[cidx];
            reg_rdata_o[CFG_FIQ_BIT] = fiq_q[cidx];
            reg_rdata_o[CFG_EN_BIT]  = en_q[cidx];
        end else if (is_isr) begin
            reg_rdata_o = win_valid ? vec_q[win_lvl] : '0;
        end else if (is_stat) begin
            reg_rdata_o[LVL_W-1:0]      = win_lvl;
            reg_rdata_o[STAT_VALID_BIT] = win_valid;
        end else if (is_ext) begin
            reg_rdata_o[1:0]          = ext_mode[eidx];
            reg_rdata_o[EXT_PEND_BIT] = ext_pend[eidx];
        end
    end

    assign irq_o = win_valid & ~win_fiq;
    assign fiq_o = win_valid & win_fiq;

endmodule

// File: rtl/pvic_top_chk.sv
module pvic_top_chk
    import pvic_pkg::*;
#(
    parameter int NUM_LVL = 32,
    parameter int DATA_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr_i,
    input logic                       reg_rd_i,
    input logic [REG_AW-1:0]          reg_addr_i,
    input logic [DATA_W-1:0]          reg_rdata_o,
    input logic                       irq_o,
    input logic                       fiq_o,
    input logic                       win_valid,
    input logic [$clog2(NUM_LVL)-1:0] win_lvl,
    input logic [$clog2(NUM_LVL):0]   thr,
    input logic                       busy
);

    assert_single_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));

    assert_line_has_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> win_valid);

    assert_winner_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ({1'b0, win_lvl} < thr));

    assert_claim_sets_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !reg_wr_i && reg_addr_i == OFS_ISR && win_valid)
        |=> (thr == $past({1'b0, win_lvl})) && busy);

    assert_empty_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !reg_wr_i && reg_addr_i == OFS_ISR && !win_valid) |=> $stable(thr));

    assert_empty_claim_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == OFS_ISR && !win_valid) |-> (reg_rdata_o == '0));

    assert_release_widens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_ISR) |=> (thr >= $past(thr)));

    assert_open_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (thr == ($clog2(NUM_LVL)+1)'(NUM_LVL)));

endmodule

bind pvic_top pvic_top_chk #(
    .NUM_LVL (NUM_LVL),
    .DATA_W  (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .win_valid   (win_valid),
    .win_lvl     (win_lvl),
    .thr         (thr),
    .busy        (busy)
);

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] src = '0;
    logic [3:0]  ext = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Behavioural reference state
    int        m_vec [32];
    int        m_sid [32];
    bit        m_en  [32];
    bit        m_fiq [32];
    int        m_thr;
    int        m_stk [$];
    bit [1:0]  m_mode [4];
    bit        m_pend [4];
    bit        m_prev [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pvic_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .ext_pin_i   (ext),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    function automatic bit m_src(int s);
        int k;
        if (s < 28) return src[s];
        k = s - 28;
        case (m_mode[k])
            2'b10:   return ext[k];
            2'b11:   return !ext[k];
            default: return m_pend[k];
        endcase
    endfunction

    function automatic int m_winner();
        for (int l = 0; l < 32; l++) begin
            if (m_en[l] && l < m_thr && m_src(m_sid[l])) return l;
        end
        return -1;
    endfunction

    function automatic logic [31:0] m_rdata(int w);
        logic [31:0] r = '0;
        if (addr < 8'h20) r = m_vec[addr];
        else if (addr < 8'h40) r = m_sid[addr-8'h20] | (m_fiq[addr-8'h20] << 5) | (m_en[addr-8'h20] << 6);
        else if (addr == 8'h40) r = (w >= 0) ? m_vec[w] : 0;
        else if (addr == 8'h41) r = (w >= 0) ? (32'h20 | w) : 0;
        else if (addr >= 8'h48 && addr < 8'h4C) r = m_mode[addr-8'h48] | (m_pend[addr-8'h48] << 3);
        return r;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int l = 0; l < 32; l++) begin
            m_vec[l] = 0; m_sid[l] = 0; m_en[l] = 0; m_fiq[l] = 0;
        end
        for (int k = 0; k < 4; k++) begin
            m_mode[k] = 0; m_pend[k] = 0; m_prev[k] = 0;
        end
        m_thr = 32;
        m_stk.delete();
    endtask

    // One clock: compare before the edge, then advance the model
    task automatic tick();
        int w;
        bit e, ctl;
        #1;
        w = m_winner();
        chk("irq", {31'b0, irq}, {31'b0, (w >= 0 && !m_fiq[w])});
        chk("fiq", {31'b0, fiq}, {31'b0, (w >= 0 && m_fiq[w])});
        if (rd) chk("rdata", rdata, m_rdata(w));
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            e = (m_mode[k] == 2'b00 && ext[k] && !m_prev[k]) ||
                (m_mode[k] == 2'b01 && !ext[k] && m_prev[k]);
            ctl = wr && (addr == 8'h48 + k);
            if (e) m_pend[k] = 1;
            else if (ctl && wdata[2]) m_pend[k] = 0;
            m_prev[k] = ext[k];
            if (ctl) m_mode[k] = wdata[1:0];
        end
        if (wr) begin
            if (addr < 8'h20) m_vec[addr] = wdata;
            else if (addr < 8'h40) begin
                m_sid[addr-8'h20] = wdata[4:0];
                m_fiq[addr-8'h20] = wdata[5];
                m_en[addr-8'h20]  = wdata[6];
            end else if (addr == 8'h40 && m_stk.size() > 0) begin
                m_thr = m_stk.pop_back();
            end
        end else if (rd && addr == 8'h40 && w >= 0) begin
            m_stk.push_back(m_thr);
            m_thr = w;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        wr = 1; addr = a; wdata = d;
        tick();
        wr = 0; wdata = '0;
    endtask

    task automatic rd_reg(logic [7:0] a);
        rd = 1; addr = a;
        tick();
        rd = 0;
    endtask

    function automatic logic [31:0] cfg(int sid, bit f, bit en);
        return sid | (f << 5) | (en << 6);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        rd_reg(8'h41); rd_reg(8'h05); rd_reg(8'h25); rd_reg(8'h40); rd_reg(8'h48);

        // R2: register map and disabled levels
        cur_req = "R2";
        foreach (m_vec[l]) begin end
        for (int l = 0; l < 32; l++) wr_reg(8'(l), 32'hA000_0000 + l * 32'h40);
        wr_reg(8'h20, cfg(29, 1, 1));
        wr_reg(8'h21, cfg(2, 1, 1));
        wr_reg(8'h22, cfg(5, 0, 0));
        wr_reg(8'h23, cfg(5, 0, 1));
        wr_reg(8'h27, cfg(5, 0, 1));
        wr_reg(8'h2A, cfg(28, 0, 1));
        wr_reg(8'h3F, cfg(0, 0, 1));
        rd_reg(8'h03); rd_reg(8'h21); rd_reg(8'h22); rd_reg(8'h1F);

        // R3: lowest enabled level wins; shared source
        cur_req = "R3";
        src[5] = 1; tick();
        src[0] = 1; tick();
        // R5: status
        cur_req = "R5";
        rd_reg(8'h41);
        // R4: FIQ routing and preemption of the line
        cur_req = "R4";
        src[2] = 1; tick(); rd_reg(8'h41);

        // R6: claim masks level 1 and below
        cur_req = "R6";
        rd_reg(8'h40); idle(2); rd_reg(8'h41);
        // R7: empty claim
        cur_req = "R7";
        rd_reg(8'h40); rd_reg(8'h41); idle(1);

        // R8: release, then nested claims
        cur_req = "R8";
        wr_reg(8'h40, 32'h0); tick();
        src[2] = 0; tick();
        rd_reg(8'h40); tick();
        src[2] = 1; tick();
        rd_reg(8'h40); tick();
        wr_reg(8'h40, 32'h1234); tick();
        src[2] = 0; tick();
        wr_reg(8'h40, 32'h0); tick();
        wr_reg(8'h40, 32'h0); tick();

        // R11: simultaneous read and write
        cur_req = "R11";
        rd = 1; wr = 1; addr = 8'h40; wdata = 32'h5;
        tick();
        rd = 0; wr = 0;
        idle(1); rd_reg(8'h41);
        rd_reg(8'h40); tick();
        rd = 1; wr = 1; addr = 8'h40; tick();
        rd = 0; wr = 0;
        rd_reg(8'h41);
        src = '0; tick();

        // R9: level modes on external pins
        cur_req = "R9";
        wr_reg(8'h49, 32'h2); tick();
        ext[1] = 1; tick(); rd_reg(8'h41);
        ext[1] = 0; tick();
        wr_reg(8'h49, 32'h3); tick();
        ext[1] = 1; tick();
        wr_reg(8'h49, 32'h2); rd_reg(8'h49);

        // R10: edge modes, pending, clear, collision
        cur_req = "R10";
        ext[0] = 1; tick(); tick();
        ext[0] = 0; tick(); rd_reg(8'h48);
        wr_reg(8'h48, 32'h4); rd_reg(8'h48);
        wr_reg(8'h48, 32'h1); ext[0] = 1; tick(); tick();
        ext[0] = 0; tick(); rd_reg(8'h48);
        wr_reg(8'h48, 32'h0); rd_reg(8'h48);
        ext[0] = 1; wr = 1; addr = 8'h48; wdata = 32'h4;
        tick();
        wr = 0; wdata = '0;
        rd_reg(8'h48); tick();
        wr_reg(8'h48, 32'h4); rd_reg(8'h48);
        ext[0] = 0; idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule